// File: doc/BRIEF.md
# Processor-Side Bus Arbitration Controller

This block decides when a processor hands its external bus to another master and when it takes the bus back. Each clock it samples the other master's request and acknowledge lines, along with error and halt lines. It drives a grant output and a float output. While the float output is high, the processor's address, data and control buffers stay in high impedance.

The processor's bus sequencer reports a locked read-modify-write sequence on `locked_i`. It marks the first read of that sequence with `first_rd_i`. After that first read, requests are deferred and no grant is issued. A request that is still pending is granted as soon as the lock ends. If error, halt and request arrive together while a grant is allowed, a relinquish-and-retry is requested. The block then grants the bus and pulses `retry_o` for one clock, so that the sequencer can repeat the cycle. An acknowledge with no request before it takes the bus at any time, including in the middle of a locked sequence.

Top module: `bus_arbiter_ctl`

## Requirements
- R1: While reset is applied and after it is released with all inputs low, `grant_o`, `bus_float_o` and `retry_o` are low.
- R2: `bus_req_i`, `bus_ack_i`, `bus_err_i` and `halt_i` each pass through a two-flop synchronizer. A change that is set up before rising edge k reaches the outputs at rising edge k+2, and not before.
- R3: From idle with no lock, a request raises `grant_o` with `bus_float_o` low. If the request is withdrawn before any acknowledge, `grant_o` falls and the block returns to idle.
- R4: An acknowledge while granted drops `grant_o` and holds `bus_float_o` high for as long as the acknowledge stays high.
- R5: After the acknowledge is negated, `bus_float_o` stays high for exactly one more clock and then falls.
- R6: An acknowledge in idle with no request raises `bus_float_o` without ever raising `grant_o`.
- R7: While `locked_i` is high and `first_rd_i` is low, a request does not raise `grant_o`. This holds even when error and halt arrive with the request, and in that case `retry_o` also stays low.
- R8: A request deferred by R7 is granted on the first clock edge at which `locked_i` is sampled low, provided the request is still high.
- R9: While `locked_i` and `first_rd_i` are both high, a request is granted as in R3.
- R10: When request, error and halt are all high in idle and a grant is allowed, `grant_o` rises. At the same edge `retry_o` rises for exactly one clock.
- R11: An acknowledge raises `bus_float_o` even while `locked_i` is high and `first_rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Request from the other master (asynchronous) |
| bus_ack_i | input | 1 | Acknowledge from the other master (asynchronous) |
| bus_err_i | input | 1 | Bus error line (asynchronous) |
| halt_i | input | 1 | Halt line (asynchronous) |
| locked_i | input | 1 | Locked read-modify-write sequence active (synchronous) |
| first_rd_i | input | 1 | Current cycle is the first read of the locked sequence (synchronous) |
| grant_o | output | 1 | Bus grant |
| bus_float_o | output | 1 | High: the processor's bus buffers are in high impedance |
| retry_o | output | 1 | One-clock pulse: a relinquish-and-retry was taken |

## Verification
The bench first targets the lock window. If requests are not deferred after the first read, a grant would appear in the middle of the sequence. If the release edge is delayed by one clock, the deferred grant would show up a cycle late. It then checks that the float output is held for one clock after the acknowledge falls; dropping it early would let two drivers fight over the bus. Finally it checks that an acknowledge alone still floats the bus inside a lock, and that a retry request is suppressed there but gives exactly a one-clock pulse when it is allowed.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GRANT  = 3'd1,
    ST_OWNED  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_FORCED = 3'd4
  } arb_state_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned ASYNC_W     = 4;

  // bit positions of the synchronized input vector
  localparam int unsigned IDX_REQ  = 0;
  localparam int unsigned IDX_ACK  = 1;
  localparam int unsigned IDX_ERR  = 2;
  localparam int unsigned IDX_HALT = 3;

  function automatic logic f_grant(arb_state_e s);
    return (s == ST_GRANT);
  endfunction

  function automatic logic f_float(arb_state_e s);
    return (s == ST_OWNED) || (s == ST_FORCED) || (s == ST_HOLD);
  endfunction

  function automatic logic f_blocked(logic locked, logic first_rd);
    return locked && !first_rd;
  endfunction

  function automatic logic f_retry_req(logic req, logic err, logic halt);
    return req && err && halt;
  endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d_i;
      end
      assign q_o = stg;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d_i};
      end
      assign q_o = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/arb_lock_filter.sv
module arb_lock_filter
  import arb_pkg::*;
(
  input  logic locked_i,
  input  logic first_rd_i,
  input  logic req_s,
  input  logic err_s,
  input  logic halt_s,
  output logic blocked_o,
  output logic req_ok_o,
  output logic retry_req_o
);
  always_comb begin
    blocked_o   = f_blocked(locked_i, first_rd_i);
    req_ok_o    = req_s && !blocked_o;
    retry_req_o = f_retry_req(req_s, err_s, halt_s) && !blocked_o;
  end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_s,
  input  logic       req_s,
  input  logic       req_ok,
  input  logic       retry_req,
  output arb_state_e state_o,
  output logic       grant_o,
  output logic       float_o,
  output logic       retry_o
);
  arb_state_e state_q, state_d;
  logic       retry_d;
  logic       grant_q, float_q, retry_q;

  always_comb begin
    state_d = state_q;
    retry_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ack_s) begin
          state_d = ST_FORCED;
        end else if (req_ok) begin
          state_d = ST_GRANT;
          retry_d = retry_req;
        end
      end
      ST_GRANT: begin
        if (ack_s)       state_d = ST_OWNED;
        else if (!req_s) state_d = ST_IDLE;
      end
      ST_OWNED, ST_FORCED: begin
        if (!ack_s) state_d = ST_HOLD;
      end
      ST_HOLD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grant_q <= 1'b0;
      float_q <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      grant_q <= f_grant(state_d);
      float_q <= f_float(state_d);
      retry_q <= retry_d;
    end
  end

  assign state_o = state_q;
  assign grant_o = grant_q;
  assign float_o = float_q;
  assign retry_o = retry_q;
endmodule

// File: rtl/bus_arbiter_ctl.sv
module bus_arbiter_ctl
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_i,
  input  logic bus_ack_i,
  input  logic bus_err_i,
  input  logic halt_i,
  input  logic locked_i,
  input  logic first_rd_i,
  output logic grant_o,
  output logic bus_float_o,
  output logic retry_o
);
  logic [ASYNC_W-1:0] raw_in, sync_in;
  logic br_s, ack_s, err_s, halt_s;
  logic blocked, req_ok, retry_req;
  arb_state_e state_q;

  always_comb begin
    raw_in           = '0;
    raw_in[IDX_REQ]  = bus_req_i;
    raw_in[IDX_ACK]  = bus_ack_i;
    raw_in[IDX_ERR]  = bus_err_i;
    raw_in[IDX_HALT] = halt_i;
  end

  arb_sync #(.W(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_in)
  );

  assign br_s   = sync_in[IDX_REQ];
  assign ack_s  = sync_in[IDX_ACK];
  assign err_s  = sync_in[IDX_ERR];
  assign halt_s = sync_in[IDX_HALT];

  arb_lock_filter u_lock (
    .locked_i(locked_i), .first_rd_i(first_rd_i),
    .req_s(br_s), .err_s(err_s), .halt_s(halt_s),
    .blocked_o(blocked), .req_ok_o(req_ok), .retry_req_o(retry_req)
  );

  arb_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ack_s(ack_s), .req_s(br_s), .req_ok(req_ok), .retry_req(retry_req),
    .state_o(state_q), .grant_o(grant_o), .float_o(bus_float_o),
    .retry_o(retry_o)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state_q,
  input logic       ack_s,
  input logic       blocked,
  input logic       grant_o,
  input logic       float_o,
  input logic       retry_o
);
  a_r4_grant_float_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && float_o));

  a_r5_float_one_extra: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_s) && float_o) |=> float_o ##1 !float_o);

  a_r6_bare_ack_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'(ST_IDLE) && ack_s) |=> (float_o && !grant_o));

  a_r7_locked_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'(ST_IDLE) && blocked) |=> (!grant_o && !retry_o));

  a_r10_retry_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> grant_o);

  a_r10_retry_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |=> !retry_o);
endmodule

bind bus_arbiter_ctl arb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .ack_s(ack_s),
  .blocked(blocked), .grant_o(grant_o), .float_o(bus_float_o),
  .retry_o(retry_o)
);

// File: tb/test_bus_arbiter_ctl.sv
`timescale 1ns/1ps
module test_bus_arbiter_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic br = 0, ack = 0, err = 0, halt = 0, lock = 0, first = 0;
  logic grant, flt, retry;
  int cyc = 0, checks = 0, errors = 0;

  typedef struct { int at; logic g; logic f; logic r; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_arbiter_ctl i_bus_arbiter_ctl (
    .clk(clk), .rst_n(rst_n), .bus_req_i(br), .bus_ack_i(ack),
    .bus_err_i(err), .halt_i(halt), .locked_i(lock), .first_rd_i(first),
    .grant_o(grant), .bus_float_o(flt), .retry_o(retry)
  );

  // driver side: expected outputs d cycles from now
  task automatic expect_in(int d, logic g, logic f, logic r, string tag);
    exp_t e;
    e.at = cyc + d; e.g = g; e.f = f; e.r = r; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor side
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.at != cyc || grant !== e.g || flt !== e.f || retry !== e.r) begin
        errors++;
        $display("FAIL %s cyc=%0d: got grant=%b float=%b retry=%b, expected %b %b %b",
                 e.tag, cyc, grant, flt, retry, e.g, e.f, e.r);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    step(3);
    checks++;
    if (grant !== 0 || flt !== 0 || retry !== 0) begin
      errors++;
      $display("FAIL R1 in reset: got %b%b%b expected 000", grant, flt, retry);
    end
    rst_n = 1'b1;
    expect_in(1, 0, 0, 0, "R1"); step(3);

    // R2/R3/R4/R5: normal hand-over
    br = 1;
    expect_in(2, 0, 0, 0, "R2"); expect_in(3, 1, 0, 0, "R3"); step(4);
    ack = 1; br = 0;
    expect_in(2, 1, 0, 0, "R2"); expect_in(3, 0, 1, 0, "R4"); step(5);
    ack = 0;
    expect_in(3, 0, 1, 0, "R5"); expect_in(4, 0, 0, 0, "R5"); step(6);

    // R3: request withdrawn before acknowledge
    br = 1; step(4);
    br = 0;
    expect_in(2, 1, 0, 0, "R3"); expect_in(3, 0, 0, 0, "R3"); step(5);

    // R6: bare acknowledge
    ack = 1;
    expect_in(2, 0, 0, 0, "R2"); expect_in(3, 0, 1, 0, "R6"); step(5);
    ack = 0;
    expect_in(3, 0, 1, 0, "R5"); expect_in(4, 0, 0, 0, "R5"); step(6);

    // R7/R8: request deferred during lock, granted on release
    lock = 1; first = 0; br = 1;
    expect_in(3, 0, 0, 0, "R7"); expect_in(6, 0, 0, 0, "R7"); step(7);
    lock = 0;
    expect_in(1, 1, 0, 0, "R8"); step(2);
    br = 0;
    expect_in(3, 0, 0, 0, "R3"); step(5);

    // R7: retry triple suppressed inside lock
    lock = 1; br = 1; err = 1; halt = 1;
    expect_in(3, 0, 0, 0, "R7"); expect_in(5, 0, 0, 0, "R7"); step(6);
    br = 0; err = 0; halt = 0; step(4);
    lock = 0;
    expect_in(1, 0, 0, 0, "R7"); step(3);

    // R9: first read of locked sequence arbitrates normally
    lock = 1; first = 1; br = 1;
    expect_in(3, 1, 0, 0, "R9"); step(4);
    br = 0; lock = 0; first = 0;
    expect_in(3, 0, 0, 0, "R9"); step(5);

    // R10: relinquish-and-retry during first read
    lock = 1; first = 1; br = 1; err = 1; halt = 1;
    expect_in(2, 0, 0, 0, "R10"); expect_in(3, 1, 0, 1, "R10");
    expect_in(4, 1, 0, 0, "R10"); step(5);
    br = 0; err = 0; halt = 0; lock = 0; first = 0;
    expect_in(3, 0, 0, 0, "R10"); step(5);

    // R11: acknowledge forces float past the first read
    lock = 1; first = 0; ack = 1;
    expect_in(3, 0, 1, 0, "R11"); step(4);
    ack = 0;
    expect_in(3, 0, 1, 0, "R11"); expect_in(4, 0, 0, 0, "R11"); step(6);
    lock = 0; step(2);

    if (sb.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    summary();
  end
endmodule